// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Hold Handshake

This core keeps wall-clock time and a calendar for the years 2000 to 2099, all in BCD. It runs on the system clock. A one-cycle strobe, `refTick`, marks each cycle of the slow reference oscillator. A sub-second divider turns those strobes into one-second ticks. It has two modes. The fixed mode expects a 32768 Hz reference. The compare mode counts up to a programmed terminal value, which is the reference rate minus one, so crystals from 32000 Hz to 4194304 Hz can be used.

Software reads several outputs:
- the live time and calendar words;
- a latched pair of both words, taken together after every tick;
- a live seconds byte. It can compare this byte with the latched pair to find a rollover that happened during a two-word read.

To set the clock, software does the following:
1. Raises the hold request and waits for the hold status.
2. Loads new words.
3. Drops the request. Counting resumes.

A global enable with a delayed status guards the mode inputs, which are taken only while the core is disabled.

Top module: `bcd_rtc_core`

## Requirements
- R1: Time word layout is seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16, all in BCD. In 24-hour mode each tick advances seconds 00–59, then minutes 00–59, then hours 00–23, and 23:59:59 wraps to 00:00:00.
- R2: Calendar word layout is weekday in bits 3:0 as binary 0–6, day in bits 15:8, month in bits 23:16 and year in bits 31:24, all in BCD. The weekday wraps 6 to 0 on each day carry, December rolls to January with a year carry, and year 99 wraps to 00. After reset the time word is 0 and the calendar word is 32'h0001_0100.
- R3: While `waitReq` is high no tick occurs. `waitStatus` follows `waitReq` after exactly two reference strobes, both when rising and when falling. Counting resumes only once `waitReq` and `waitStatus` are both low.
- R4: A `loadStrobe` writes `timeIn`/`calIn` into the live words and restarts the divider. It does so only while `waitStatus` is high or `enStatus` is low. At any other time the strobe leaves the live words unchanged.
- R5: `enStatus` follows `cntEnable` after exactly two reference strobes. Ticks occur only while `enStatus` is high, and the divider is held at zero while it is low.
- R6: `cmpMode`, `cmpValue` and `mode24h` are taken into the core only while both `cntEnable` and `enStatus` are low. Changes at any other time have no effect on counting or on the hour format.
- R7: In compare mode (`cmpMode`=1) a tick comes every `cmpValue`+1 counted reference strobes. In fixed mode it comes every 32768 strobes.
- R8: In 12-hour mode (`mode24h`=0) the hour byte holds a PM flag in bit 5 (word bit 21) and the BCD hour 01–12 in bits 4:0. Each step is a new tick:
  - 11 AM becomes 12 PM (8'h32).
  - 12 PM becomes 1 PM (8'h21).
  - 11:59:59 PM becomes 12 AM (8'h12) with a day carry.
  - 12 AM becomes 1 AM (8'h01).
- R9: The last day of a month is 30 for April, June, September and November, and 31 for the other months except February. February ends on 29 when the year value is a multiple of 4 and on 28 otherwise.
- R10: On the clock after each tick or accepted load, `timeSnap` and `calSnap` both take the live words. `secLive` always equals the live seconds byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | One-cycle strobe per reference oscillator cycle |
| cntEnable | input | 1 | Global counter enable |
| cmpMode | input | 1 | 1 selects compare divider, 0 fixed 32768 |
| cmpValue | input | 22 | Divider terminal value (reference rate − 1) |
| mode24h | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour |
| waitReq | input | 1 | Hold request |
| loadStrobe | input | 1 | Load `timeIn`/`calIn` into the live words |
| timeIn | input | 24 | Time word to load |
| calIn | input | 32 | Calendar word to load |
| timeLive | output | 24 | Live time word |
| calLive | output | 32 | Live calendar word |
| timeSnap | output | 24 | Time word latched with the last tick or load |
| calSnap | output | 32 | Calendar word latched with the last tick or load |
| secLive | output | 8 | Live seconds byte |
| enStatus | output | 1 | Enable status, two reference strobes behind `cntEnable` |
| waitStatus | output | 1 | Hold status, two reference strobes behind `waitReq` |

## Verification
Timing of each result:
- The live words change on the clock edge that carries the terminal reference strobe.
- The latched pair changes one clock later.
- Both status outputs change on the edge of the second reference strobe after their input moves.

The bench supplies reference strobes only in counted bursts and starts each burst right after a hold release. As a result, the number of seconds elapsed is an exact function of the burst length. Every check is sampled on a falling edge after at least two idle clocks. For the status outputs, the bench checks after one strobe (unchanged) and after two (changed).

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic tick;
    logic load;
    logic h24;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] lastDayBcd(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] mod4;
    mod4 = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mon)
      8'h02: return (mod4[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_W       = 22,
  parameter int FIXED_COUNT = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refTick,
  input  logic             cntEnable,
  input  logic             cmpMode,
  input  logic [DIV_W-1:0] cmpValue,
  input  logic             mode24h,
  input  logic             waitReq,
  input  logic             loadStrobe,
  output rtcStrobe_t       stb,
  output logic             enStatus,
  output logic             waitStatus
);

  localparam logic [DIV_W-1:0] FIXED_LIMIT = DIV_W'(FIXED_COUNT - 1);

  logic [SYNC_STAGES-1:0] enSync, waitSync;
  logic                   cmpModeQ, mode24Q;
  logic [DIV_W-1:0]       cmpValueQ, divQ, limit;
  logic                   run, loadOk, atLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enSync   <= '0;
      waitSync <= '0;
    end else if (refTick) begin
      enSync   <= {enSync[SYNC_STAGES-2:0], cntEnable};
      waitSync <= {waitSync[SYNC_STAGES-2:0], waitReq};
    end
  end

  assign enStatus   = enSync[SYNC_STAGES-1];
  assign waitStatus = waitSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpModeQ  <= 1'b0;
      cmpValueQ <= FIXED_LIMIT;
      mode24Q   <= 1'b1;
    end else if (!cntEnable && !enStatus) begin
      cmpModeQ  <= cmpMode;
      cmpValueQ <= cmpValue;
      mode24Q   <= mode24h;
    end
  end

  assign limit   = cmpModeQ ? cmpValueQ : FIXED_LIMIT;
  assign run     = enStatus && !waitReq && !waitStatus;
  assign loadOk  = loadStrobe && (waitStatus || !enStatus);
  assign atLimit = (divQ >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divQ <= '0;
    else if (!enStatus || loadOk) divQ <= '0;
    else if (run && refTick) divQ <= atLimit ? '0 : divQ + 1'b1;
  end

  assign stb.tick = run && refTick && atLimit;
  assign stb.load = loadOk;
  assign stb.h24  = mode24Q;

  assert_en_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enStatus != $past(enStatus)) |-> $past(refTick));

  assert_wait_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waitStatus != $past(waitStatus)) |-> $past(refTick));

  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enStatus) && enStatus) |-> $stable({cmpModeQ, cmpValueQ, mode24Q}));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rtcStrobe_t  stb,
  input  logic [23:0] timeIn,
  input  logic [31:0] calIn,
  output logic [23:0] timeQ,
  output logic [31:0] calQ,
  output logic [23:0] timeSnap,
  output logic [31:0] calSnap
);

  localparam logic [31:0] CAL_RESET = 32'h0001_0100;

  logic [7:0] sec, minute, hr, day, mon, yr, lastDay;
  logic [3:0] wday;
  logic [7:0] nSec, nMin, nHr, nDay, nMon, nYr, hr12;
  logic [3:0] nWday;
  logic       cMin, cHr, cDay, cMon, cYr, snapEn;

  assign sec    = timeQ[7:0];
  assign minute = timeQ[15:8];
  assign hr     = timeQ[23:16];
  assign wday   = calQ[3:0];
  assign day    = calQ[15:8];
  assign mon    = calQ[23:16];
  assign yr     = calQ[31:24];
  assign lastDay = lastDayBcd(mon, yr);
  assign hr12   = {3'b000, hr[4:0]};

  always_comb begin
    cMin = (sec == 8'h59);
    nSec = cMin ? 8'h00 : bcdInc(sec);
    cHr  = cMin && (minute == 8'h59);
    nMin = cMin ? ((minute == 8'h59) ? 8'h00 : bcdInc(minute)) : minute;
    cDay = 1'b0;
    nHr  = hr;
    if (cHr) begin
      if (stb.h24) begin
        cDay = (hr == 8'h23);
        nHr  = cDay ? 8'h00 : bcdInc(hr);
      end else if (hr12 == 8'h11) begin
        nHr  = {2'b00, !hr[5], 5'h12};
        cDay = hr[5];
      end else if (hr12 == 8'h12) begin
        nHr  = {2'b00, hr[5], 5'h01};
      end else begin
        nHr  = {2'b00, hr[5], bcdInc(hr12)[4:0]};
      end
    end
    nWday = wday;
    nDay  = day;
    cMon  = 1'b0;
    if (cDay) begin
      nWday = (wday >= 4'd6) ? 4'd0 : wday + 4'd1;
      cMon  = (day == lastDay);
      nDay  = cMon ? 8'h01 : bcdInc(day);
    end
    cYr  = cMon && (mon == 8'h12);
    nMon = cMon ? ((mon == 8'h12) ? 8'h01 : bcdInc(mon)) : mon;
    nYr  = cYr ? ((yr == 8'h99) ? 8'h00 : bcdInc(yr)) : yr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeQ  <= '0;
      calQ   <= CAL_RESET;
      snapEn <= 1'b0;
    end else begin
      snapEn <= stb.tick || stb.load;
      if (stb.load) begin
        timeQ <= timeIn;
        calQ  <= calIn;
      end else if (stb.tick) begin
        timeQ <= {nHr, nMin, nSec};
        calQ  <= {nYr, nMon, nDay, calQ[7:4], nWday};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeSnap <= '0;
      calSnap  <= CAL_RESET;
    end else if (snapEn) begin
      timeSnap <= timeQ;
      calSnap  <= calQ;
    end
  end

  assert_sec_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[7:4] <= 4'd5) && (sec[3:0] <= 4'd9));

  assert_month_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon >= 8'h01) && (mon <= 8'h12));

  assert_day_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (day >= 8'h01) && (day <= lastDay));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_W       = 22,
  parameter int FIXED_COUNT = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refTick,
  input  logic             cntEnable,
  input  logic             cmpMode,
  input  logic [DIV_W-1:0] cmpValue,
  input  logic             mode24h,
  input  logic             waitReq,
  input  logic             loadStrobe,
  input  logic [23:0]      timeIn,
  input  logic [31:0]      calIn,
  output logic [23:0]      timeLive,
  output logic [31:0]      calLive,
  output logic [23:0]      timeSnap,
  output logic [31:0]      calSnap,
  output logic [7:0]       secLive,
  output logic             enStatus,
  output logic             waitStatus
);

  rtcStrobe_t stb;

  rtc_ctrl #(.DIV_W(DIV_W), .FIXED_COUNT(FIXED_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .refTick(refTick), .cntEnable(cntEnable),
    .cmpMode(cmpMode), .cmpValue(cmpValue), .mode24h(mode24h),
    .waitReq(waitReq), .loadStrobe(loadStrobe), .stb(stb),
    .enStatus(enStatus), .waitStatus(waitStatus)
  );

  rtc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .timeIn(timeIn), .calIn(calIn),
    .timeQ(timeLive), .calQ(calLive), .timeSnap(timeSnap), .calSnap(calSnap)
  );

  assign secLive = timeLive[7:0];

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waitStatus && !loadStrobe) |=> $stable(timeLive) && $stable(calLive));

endmodule

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refTick = 1'b0, cntEnable = 1'b0, cmpMode = 1'b0, mode24h = 1'b1;
  logic        waitReq = 1'b0, loadStrobe = 1'b0;
  logic [21:0] cmpValue = '0;
  logic [23:0] timeIn = '0;
  logic [31:0] calIn = '0;
  logic [23:0] timeLive, timeSnap;
  logic [31:0] calLive, calSnap;
  logic [7:0]  secLive;
  logic        enStatus, waitStatus;

  int checks = 0, failures = 0;
  int s, mi, h, wd, d, mo, y;
  int perSec = 4;
  bit fmt24 = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .refTick(refTick), .cntEnable(cntEnable),
    .cmpMode(cmpMode), .cmpValue(cmpValue), .mode24h(mode24h),
    .waitReq(waitReq), .loadStrobe(loadStrobe), .timeIn(timeIn), .calIn(calIn),
    .timeLive(timeLive), .calLive(calLive), .timeSnap(timeSnap), .calSnap(calSnap),
    .secLive(secLive), .enStatus(enStatus), .waitStatus(waitStatus)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int dim(input int m, input int yy);
    if (m == 2) return (yy % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [23:0] packTime(input int hh, input int mm, input int ss, input bit f24);
    int h12;
    logic [7:0] hb;
    h12 = (hh % 12 == 0) ? 12 : hh % 12;
    hb  = f24 ? bcd(hh) : (bcd(h12) | ((hh >= 12) ? 8'h20 : 8'h00));
    return {hb, bcd(mm), bcd(ss)};
  endfunction

  function automatic logic [31:0] packCal(input int dd, input int mm, input int yy, input int w);
    return {bcd(yy), bcd(mm), bcd(dd), 4'h0, 4'(w)};
  endfunction

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) begin
      s++;
      if (s == 60) begin
        s = 0; mi++;
        if (mi == 60) begin
          mi = 0; h++;
          if (h == 24) begin
            h = 0; wd = (wd + 1) % 7; d++;
            if (d > dim(mo, y)) begin
              d = 1; mo++;
              if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refRun(input int n);
    if (n > 0) begin
      @(negedge clk); refTick = 1'b1;
      repeat (n) @(negedge clk);
      refTick = 1'b0;
    end
  endtask

  task automatic loadNow(input logic [23:0] t, input logic [31:0] c);
    @(negedge clk); timeIn = t; calIn = c; loadStrobe = 1'b1;
    @(negedge clk); loadStrobe = 1'b0;
  endtask

  task automatic checkAll(input string req);
    idle(2);
    check({req, " time"}, 32'(timeLive), 32'(packTime(h, mi, s, fmt24)));
    check({req, " cal"}, calLive, packCal(d, mo, y, wd));
    check({req, " R10 snapT"}, 32'(timeSnap), 32'(packTime(h, mi, s, fmt24)));
    check({req, " R10 snapC"}, calSnap, packCal(d, mo, y, wd));
    check({req, " R10 sec"}, 32'(secLive), 32'(bcd(s)));
  endtask

  task automatic trial(input int n, input string req);
    waitReq = 1'b1; refRun(2);
    loadNow(packTime(h, mi, s, fmt24), packCal(d, mo, y, wd));
    waitReq = 1'b0; refRun(2);
    refRun(n * perSec);
    advance(n);
    checkAll(req);
  endtask

  task automatic setModel(input int hh, input int mm, input int ss, input int dd,
                          input int mn, input int yy, input int w);
    h = hh; mi = mm; s = ss; d = dd; mo = mn; y = yy; wd = w;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2 reset values
    check("R2 reset time", 32'(timeLive), 32'h0);
    check("R2 reset cal", calLive, 32'h0001_0100);
    check("R5 reset en", 32'(enStatus), 32'h0);

    cmpMode = 1'b1; cmpValue = 22'd3; mode24h = 1'b1; perSec = 4;
    idle(2);
    cntEnable = 1'b1;
    refRun(1); idle(1);
    check("R5 en after 1", 32'(enStatus), 32'h0);
    refRun(1); idle(1);
    check("R5 en after 2", 32'(enStatus), 32'h1);

    waitReq = 1'b1;
    refRun(1); idle(1);
    check("R3 wait after 1", 32'(waitStatus), 32'h0);
    refRun(1); idle(1);
    check("R3 wait after 2", 32'(waitStatus), 32'h1);

    // R1 R2 year/day wrap, then R3 release
    setModel(23, 59, 59, 31, 12, 99, 6);
    loadNow(packTime(h, mi, s, 1'b1), packCal(d, mo, y, wd));
    refRun(8); idle(1);
    check("R3 held no count", 32'(timeLive), 32'(packTime(23, 59, 59, 1'b1)));
    waitReq = 1'b0;
    refRun(1); idle(1);
    check("R3 release after 1", 32'(waitStatus), 32'h1);
    refRun(1); idle(1);
    check("R3 release after 2", 32'(waitStatus), 32'h0);
    refRun(3); idle(2);
    check("R7 no tick before limit", 32'(timeLive), 32'(packTime(23, 59, 59, 1'b1)));
    refRun(1); advance(1);
    checkAll("R1 R2 wrap");

    // R9 month lengths
    setModel(23, 59, 58, 28, 2, 24, 3); trial(2, "R9 leap feb");
    setModel(23, 59, 59, 28, 2, 23, 3); trial(1, "R9 plain feb");
    setModel(23, 59, 59, 30, 4, 11, 2); trial(1, "R9 april");
    setModel(23, 59, 59, 30, 1, 11, 2); trial(1, "R9 jan 30");

    // R4 load ignored while running
    loadNow(24'h12_34_56, 32'h0506_0701);
    idle(2);
    check("R4 ignored time", 32'(timeLive), 32'(packTime(h, mi, s, 1'b1)));
    check("R4 ignored cal", calLive, packCal(d, mo, y, wd));

    // R6 mode inputs ignored while enabled
    cmpValue = 22'd9; mode24h = 1'b0;
    refRun(4); advance(1);
    checkAll("R6 R7 mode frozen");
    cmpValue = 22'd3; mode24h = 1'b1;

    // random 24h trials
    for (int k = 0; k < 20; k++) begin
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = ($urandom % 2 == 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s  = int'($urandom % 60);
      wd = int'($urandom % 7);
      trial(1 + int'($urandom % 90), "R1 R2 R9 random");
    end

    // R5 disable, R8 12h mode
    cntEnable = 1'b0;
    refRun(1); idle(1);
    check("R5 drop after 1", 32'(enStatus), 32'h1);
    refRun(1); idle(1);
    check("R5 drop after 2", 32'(enStatus), 32'h0);
    mode24h = 1'b0; fmt24 = 1'b0;
    idle(2);
    cntEnable = 1'b1; refRun(2);
    setModel(23, 59, 58, 28, 2, 24, 5); trial(3, "R8 pm to am");
    setModel(11, 59, 59, 10, 3, 24, 0); trial(1, "R8 am to pm");
    setModel(12, 59, 59, 10, 3, 24, 0); trial(1, "R8 12pm to 1pm");
    setModel(0, 59, 59, 10, 3, 24, 0);  trial(1, "R8 12am to 1am");
    for (int k = 0; k < 4; k++) begin
      setModel(int'($urandom % 24), 59, int'($urandom % 60), 15, 6, 30, 1);
      trial(1 + int'($urandom % 90), "R8 random");
    end

    // R7 fixed mode
    cntEnable = 1'b0; refRun(2);
    cmpMode = 1'b0; mode24h = 1'b1; fmt24 = 1'b1;
    idle(2);
    cntEnable = 1'b1; refRun(2);
    setModel(10, 20, 30, 5, 5, 5, 5);
    waitReq = 1'b1; refRun(2);
    loadNow(packTime(h, mi, s, 1'b1), packCal(d, mo, y, wd));
    waitReq = 1'b0; refRun(2);
    refRun(32767); idle(2);
    check("R7 fixed before", 32'(timeLive), 32'(packTime(10, 20, 30, 1'b1)));
    refRun(1); advance(1);
    checkAll("R7 fixed tick");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule